// File: doc/BRIEF.md
# Cache Line Range Maintenance Engine

This block drives clean and invalidate commands, one cache line at a time, toward a tag/state array. Software sets up a range operation in two steps. It first writes a start address. It then writes an end address, and the operation type is encoded in the kind of that second write. The second write launches a walk over every 32-byte line from the start line up to and including the end line. Each line goes out on a command port with a valid/ready handshake.

While a walk is in flight, a stall output tells the requesting pipeline to hold. The engine also accepts commands that act on one line only: clean, invalidate, or clean plus invalidate at a given address. It also accepts a single invalidate-everything command. These share the same command port and the same stall behaviour.

A range must lie inside one 4 KiB page, because only the start address is translated. A range that breaks this rule, or that runs backwards, or that has no start armed before it, issues nothing. Instead it raises an error flag.

Top module: `cache_range_engine`

## Requirements
- R1: After reset, `stall`, `cmd_valid` and `err` are low.
- R2: A request of kind 0 latches the line of `req_addr` as the range start and issues no command; `stall` stays low. A later kind-0 request replaces the earlier start.
- R3: A request of kind 1 (clean) or kind 2 (invalidate) takes `req_addr` as the end address and walks every line from the start line to the end line, inclusive, in ascending order, stepping by 32. Address bits [4:0] are ignored. Kind 1 issues `cmd_op` 0 on each line and kind 2 issues `cmd_op` 1.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr` and `cmd_op` hold steady. The next line is presented only after a cycle in which both are high.
- R5: `stall` rises in the cycle after an accepted command-issuing request. It falls in the cycle after the final line's handshake.
- R6: If the start and end addresses differ in bits [31:12] (different 4 KiB pages), the range end sets `err` to 1 and issues no command, and `stall` stays low.
- R7: If the end line is below the start line, the range end sets `err` to 1 and issues no command.
- R8: Each range end consumes the armed start. A range end with no kind-0 request since the previous range end sets `err` to 1 and issues no command.
- R9: `err` is rewritten only by range ends: a legal one clears it. Single-line and invalidate-all requests leave it unchanged.
- R10: Kinds 3, 4 and 5 each issue one command at the line of `req_addr`, with `cmd_op` 0 (clean), 1 (invalidate) and 2 (clean plus invalidate) respectively.
- R11: Kind 6 issues one command with `cmd_op` 3 and `cmd_addr` 0, whatever `req_addr` holds.
- R12: Requests presented while `stall` is high are ignored: they issue no extra command and do not extend the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 3 | Request kind, encoded as in R2, R3, R10 and R11 |
| req_addr | input | 32 | Byte address carried by the request |
| stall | output | 1 | Requester hold while commands are outstanding |
| err | output | 1 | Result of the last range end: 1 if it was illegal |
| cmd_valid | output | 1 | A per-line command is presented |
| cmd_op | output | 2 | 0 clean, 1 invalidate, 2 clean plus invalidate, 3 invalidate all |
| cmd_addr | output | 32 | Line address of the command |
| cmd_ready | input | 1 | Array accepts the presented command |

## Verification
The hardest condition to reach from the ports is a request that arrives in the middle of a walk. The stimulus must land inside a window whose length depends on how the array throttles the walk. The bench handles this by counting completed handshakes inside the walk loop. After the first line is accepted, it drives a single-line request while the ready line is being randomly withheld. It then checks that the total line count and the cycle in which the stall falls are unchanged. Error cases are also hard to reach: a range whose end sits just past a page edge, and a range end arriving with no armed start. These are reached by directed sequences, and random ranges near page edges cover them further.

// File: rtl/crme_pkg.sv
package crme_pkg;

  typedef enum logic [2:0] {
    K_SET_START  = 3'd0,
    K_END_CLEAN  = 3'd1,
    K_END_INV    = 3'd2,
    K_LINE_CLEAN = 3'd3,
    K_LINE_INV   = 3'd4,
    K_LINE_CINV  = 3'd5,
    K_INV_ALL    = 3'd6
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_CLEAN     = 2'd0,
    OP_INV       = 2'd1,
    OP_CLEAN_INV = 2'd2,
    OP_INV_ALL   = 2'd3
  } line_op_e;

endpackage

// File: rtl/crme_arm.sv
// Request decoder: holds the armed start line and judges range legality.
module crme_arm
  import crme_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  output logic          go,
  output line_op_e      go_op,
  output logic [AW-1:0] go_first,
  output logic [AW-1:0] go_last,
  output logic          bad,
  output logic          range_end
);

  logic [AW-1:0] start_q, start_d;
  logic          armed_q, armed_d;
  logic          en;
  logic [AW-1:0] line;
  logic          same_page;
  logic          ordered;

  assign line      = {addr[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
  assign same_page = (line[AW-1:PAGE_BITS] == start_q[AW-1:PAGE_BITS]);
  assign ordered   = (line >= start_q);

  always_comb begin
    go        = 1'b0;
    bad       = 1'b0;
    range_end = 1'b0;
    go_op     = OP_CLEAN;
    go_first  = line;
    go_last   = line;
    start_d   = start_q;
    armed_d   = armed_q;
    en        = 1'b0;
    if (accept) begin
      case (req_kind_e'(kind))
        K_SET_START: begin
          start_d = line;
          armed_d = 1'b1;
          en      = 1'b1;
        end
        K_END_CLEAN, K_END_INV: begin
          range_end = 1'b1;
          armed_d   = 1'b0;
          en        = 1'b1;
          go_first  = start_q;
          go_op     = (req_kind_e'(kind) == K_END_INV) ? OP_INV : OP_CLEAN;
          if (armed_q && same_page && ordered) go = 1'b1;
          else                                 bad = 1'b1;
        end
        K_LINE_CLEAN: begin
          go    = 1'b1;
          go_op = OP_CLEAN;
        end
        K_LINE_INV: begin
          go    = 1'b1;
          go_op = OP_INV;
        end
        K_LINE_CINV: begin
          go    = 1'b1;
          go_op = OP_CLEAN_INV;
        end
        K_INV_ALL: begin
          go       = 1'b1;
          go_op    = OP_INV_ALL;
          go_first = '0;
          go_last  = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      armed_q <= 1'b0;
    end else if (en) begin
      start_q <= start_d;
      armed_q <= armed_d;
    end
  end

  // R3/R6/R7: a launch and a refusal never happen together
  p_go_bad_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go, bad}));

  // R6: a launched range stays inside one page
  p_launch_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && range_end) |-> (go_first[AW-1:PAGE_BITS] == go_last[AW-1:PAGE_BITS]));

  // R8: a range end disarms the start
  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    range_end |=> !armed_q);

endmodule

// File: rtl/crme_walker.sv
// Walks line addresses from first to last with one handshake per line.
module crme_walker
  import crme_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  line_op_e      go_op,
  input  logic [AW-1:0] go_first,
  input  logic [AW-1:0] go_last,
  input  logic          cmd_ready,
  output logic          busy,
  output logic          cmd_valid,
  output line_op_e      cmd_op,
  output logic [AW-1:0] cmd_addr
);

  localparam logic [AW-1:0] STEP = AW'(1) << LINE_BITS;

  typedef enum logic {W_IDLE, W_RUN} wstate_e;

  wstate_e       state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] last_q, last_d;
  line_op_e      op_q, op_d;
  logic          en;
  logic          xfer;
  logic          at_end;

  assign xfer   = (state_q == W_RUN) && cmd_ready;
  assign at_end = (cur_q == last_q);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    op_d    = op_q;
    en      = 1'b0;
    if (go) begin
      state_d = W_RUN;
      cur_d   = go_first;
      last_d  = go_last;
      op_d    = go_op;
      en      = 1'b1;
    end else if (xfer) begin
      en = 1'b1;
      if (at_end) state_d = W_IDLE;
      else        cur_d   = cur_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      op_q    <= OP_CLEAN;
    end else if (en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      op_q    <= op_d;
    end
  end

  assign busy      = (state_q == W_RUN);
  assign cmd_valid = (state_q == W_RUN);
  assign cmd_op    = op_q;
  assign cmd_addr  = cur_q;

  // R12: launches only reach an idle walker
  p_go_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R4: a waiting command holds address and op
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_op)));

  // R3: after a non-final handshake the next line is one step higher
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_addr != last_q)) |=>
      (cmd_valid && (cmd_addr == $past(cmd_addr) + STEP)));

  // R5: the walk only ends right after a handshake
  p_end_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_valid && cmd_ready));

  // R3: the walk never passes its last line
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr <= last_q));

endmodule

// File: rtl/cache_range_engine.sv
module cache_range_engine
  import crme_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  output logic          stall,
  output logic          err,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  input  logic          cmd_ready
);

  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic          accept;
  logic          go_w;
  line_op_e      go_op_w;
  logic [AW-1:0] go_first_w;
  logic [AW-1:0] go_last_w;
  logic          bad_w;
  logic          range_end_w;
  logic          busy_w;
  line_op_e      op_w;
  logic          err_q, err_d;

  assign accept = req_valid && !busy_w;

  crme_arm #(
    .AW(AW), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)
  ) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind      (req_kind),
    .addr      (req_addr),
    .go        (go_w),
    .go_op     (go_op_w),
    .go_first  (go_first_w),
    .go_last   (go_last_w),
    .bad       (bad_w),
    .range_end (range_end_w)
  );

  crme_walker #(
    .AW(AW), .LINE_BITS(LINE_BITS)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_w),
    .go_op     (go_op_w),
    .go_first  (go_first_w),
    .go_last   (go_last_w),
    .cmd_ready (cmd_ready),
    .busy      (busy_w),
    .cmd_valid (cmd_valid),
    .cmd_op    (op_w),
    .cmd_addr  (cmd_addr)
  );

  always_comb begin
    err_d = err_q;
    if (range_end_w) err_d = bad_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_q <= 1'b0;
    else if (range_end_w) err_q <= err_d;
  end

  assign stall  = busy_w;
  assign err    = err_q;
  assign cmd_op = op_w;

  // R6/R7: a fresh error never comes with activity
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!stall && !cmd_valid));

  // R12: nothing is launched while the requester is held
  p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !go_w);

  // R9: err changes only on a range end
  p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !range_end_w |=> $stable(err));

endmodule

// File: tb/tb_cache_range_engine.sv
`timescale 1ns/1ps
module tb_cache_range_engine;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [31:0] req_addr;
  logic        stall;
  logic        err;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic        cmd_ready;

  int checks = 0;
  int errors = 0;
  int unsigned seed_init;

  cache_range_engine dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .stall     (stall),
    .err       (err),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_ready (cmd_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] f_line(input logic [31:0] a);
    return a & 32'hFFFF_FFE0;
  endfunction

  function automatic int f_nlines(input logic [31:0] s, input logic [31:0] e);
    logic [31:0] ls, le;
    ls = f_line(s);
    le = f_line(e);
    if (ls[31:12] != le[31:12]) return 0;
    if (le < ls) return 0;
    return int'((le - ls) >> 5) + 1;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one request, then serve the command port until stall drops.
  task automatic run(input logic [2:0] kind, input logic [31:0] addr,
                     input logic [1:0] eop, input logic [31:0] efirst,
                     input int nl, input string tag, input bit inject);
    int cnt;
    int guard;
    logic [31:0] exp;
    bit last_ack;
    bit waiting;
    logic [31:0] wait_addr;
    logic [1:0]  wait_op;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(stall == (nl > 0), {tag, " R5 stall rise"}, 32'(stall), 32'(nl > 0));
    cnt = 0; guard = 0; exp = efirst; last_ack = 0; waiting = 0;
    wait_addr = '0; wait_op = '0;
    while (stall && guard < 2000) begin
      cmd_ready = ($urandom() % 3) != 0;
      if (inject && cnt == 1) begin
        req_valid = 1'b1;
        req_kind  = 3'd4;
        req_addr  = 32'h0000_7F40;
      end else begin
        req_valid = 1'b0;
      end
      #1;
      if (waiting)
        chk(cmd_valid && cmd_addr == wait_addr && cmd_op == wait_op,
            {tag, " R4 hold"}, cmd_addr, wait_addr);
      last_ack = cmd_valid && cmd_ready;
      waiting  = cmd_valid && !cmd_ready;
      wait_addr = cmd_addr;
      wait_op   = cmd_op;
      if (last_ack) begin
        chk(cmd_addr == exp, {tag, " R3 line address"}, cmd_addr, exp);
        chk(cmd_op == eop, {tag, " R3 op"}, 32'(cmd_op), 32'(eop));
        exp = exp + 32'd32;
        cnt++;
      end
      @(negedge clk);
      guard++;
    end
    cmd_ready = 1'b0;
    req_valid = 1'b0;
    chk(cnt == nl, {tag, " R3 line count"}, 32'(cnt), 32'(nl));
    if (nl > 0) chk(last_ack, {tag, " R5 stall falls after final ack"}, 32'(last_ack), 32'd1);
    @(negedge clk);
    chk(!stall && !cmd_valid, {tag, " R12 idle after walk"}, 32'({stall, cmd_valid}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pg, so, eo, s, e;
    int m, nl;
    logic [2:0] k;
    seed_init = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !cmd_valid && !err, "R1 reset state",
        32'({stall, cmd_valid, err}), 32'd0);

    // R2: start alone does nothing; a second start replaces the first
    run(3'd0, 32'h0000_1000, 2'd0, 32'h0, 0, "R2 start only", 0);
    run(3'd0, 32'h0000_2040, 2'd0, 32'h0, 0, "R2 start replace", 0);
    run(3'd1, 32'h0000_20A0, 2'd0, 32'h0000_2040, 4, "R2 clean range", 0);
    chk(err == 1'b0, "R9 err after legal", 32'(err), 32'd0);

    // R3 + R12: unaligned bounds, invalidate, request injected mid-walk
    run(3'd0, 32'h0000_3013, 2'd0, 32'h0, 0, "R3 start", 0);
    run(3'd2, 32'h0000_307F, 2'd1, 32'h0000_3000, 4, "R12 inv range inject", 1);

    // R3: single-line range
    run(3'd0, 32'h0000_4020, 2'd0, 32'h0, 0, "R3 start", 0);
    run(3'd1, 32'h0000_403F, 2'd0, 32'h0000_4020, 1, "R3 one line", 0);

    // R6: cross-page
    run(3'd0, 32'h0000_5FE0, 2'd0, 32'h0, 0, "R6 start", 0);
    run(3'd2, 32'h0000_6000, 2'd1, 32'h0, 0, "R6 cross page", 0);
    chk(err == 1'b1, "R6 err", 32'(err), 32'd1);

    // R8: end with no armed start
    run(3'd0, 32'h0000_5000, 2'd0, 32'h0, 0, "R8 start", 0);
    run(3'd1, 32'h0000_5000, 2'd0, 32'h0000_5000, 1, "R9 legal clears", 0);
    chk(err == 1'b0, "R9 err cleared", 32'(err), 32'd0);
    run(3'd1, 32'h0000_5020, 2'd0, 32'h0, 0, "R8 unarmed end", 0);
    chk(err == 1'b1, "R8 err", 32'(err), 32'd1);

    // R7: backwards range
    run(3'd0, 32'h0000_6100, 2'd0, 32'h0, 0, "R7 start", 0);
    run(3'd1, 32'h0000_60E0, 2'd0, 32'h0, 0, "R7 backwards", 0);
    chk(err == 1'b1, "R7 err", 32'(err), 32'd1);

    // R10/R11: single-line ops and invalidate-all leave err untouched
    run(3'd3, 32'h0000_7123, 2'd0, 32'h0000_7120, 1, "R10 line clean", 0);
    run(3'd4, 32'h0000_7144, 2'd1, 32'h0000_7140, 1, "R10 line inv", 0);
    run(3'd5, 32'h0000_717F, 2'd2, 32'h0000_7160, 1, "R10 line clean+inv", 0);
    run(3'd6, 32'h0000_DEAD, 2'd3, 32'h0, 1, "R11 inv all", 0);
    chk(err == 1'b1, "R9 err kept by line ops", 32'(err), 32'd1);

    // R3: whole page
    run(3'd0, 32'h0000_8000, 2'd0, 32'h0, 0, "R3 start", 0);
    run(3'd1, 32'h0000_8FFF, 2'd0, 32'h0000_8000, 128, "R3 full page", 0);
    chk(err == 1'b0, "R9 err after full page", 32'(err), 32'd0);

    // Random ranges around page edges
    for (int i = 0; i < 40; i++) begin
      pg = $urandom() & 32'hFFFF_F000;
      so = $urandom() % 4096;
      s  = pg | so;
      m  = int'($urandom() % 8);
      if (m == 0)      e = s + 32'h1000;
      else if (m == 1) e = s - 32'd96;
      else begin
        eo = so + ($urandom() % 1024);
        if (eo > 32'd4095) eo = 32'd4095;
        e = pg | eo;
      end
      k  = (($urandom() % 2) == 0) ? 3'd1 : 3'd2;
      nl = f_nlines(s, e);
      run(3'd0, s, 2'd0, 32'h0, 0, "R2 random start", 0);
      run(k, e, (k == 3'd2) ? 2'd1 : 2'd0, f_line(s), nl, "R3 random range", 0);
      chk(err == (nl == 0), "R6 R7 random err", 32'(err), 32'(nl == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule